// File: doc/BRIEF.md
# Block-Write Transmit Sequencer

The sequencer moves a block of data from a storage-media decoder onto a serial bus. It sends the data as a run of block-write request packets into the initiator's memory. Software programs three settings: a destination byte address, a total length, and a payload size per packet. It then pulses `start`. From that point on the sequencer needs no software help. It pulls 32-bit words from the decoder with a request/valid handshake and stores them in a transmit FIFO. Once a full packet's payload has collected, it streams a generated two-word header followed by that payload to the link core.

After each packet the sequencer waits for the acknowledge code. When the acknowledge says the write is pending, it also waits for the matching write-response packet. If the outcome is good, the address moves forward, the remaining length shrinks, and the next packet is built. Any bad acknowledge, bad response code or missing response stops the transfer. The sequencer then flags an error, pulses an interrupt, and keeps the final acknowledge and response codes for software to read.

Lengths and payload sizes are counted in 32-bit words. Addresses are byte addresses. The payload size must lie between 1 and `FIFO_DEPTH`. `FIFO_DEPTH` must be a power of two.

Top module: `blkwr_tx_seq`

## Requirements
- R1: After reset, and until `start` is pulsed while idle, `busy`, `dataReq` and `linkVld` stay low. A `start` pulse while busy is ignored, and the running transfer uses the settings latched at its own start.
- R2: One decoder word is taken at each clock edge where both `dataReq` and `dataVld` are high. `dataReq` is only high while busy.
- R3: Each packet begins with two header words.
  - Word 0 has the payload byte count in [31:16], a 6-bit transaction label in [15:10], 0 in [9:8], block-write code 0x1 in [7:4] and 0 in [3:0].
  - Word 1 is the destination byte address.
  - The label is 0 after reset and goes up by one (wrapping) for each packet whose outcome is decided.
- R4: A packet is offered only once the FIFO holds its whole payload. `linkSop` marks header word 0 and `linkEop` marks the last payload word. While `linkRdy` is low, the offered word and its flags are held.
- R5: `dataReq` is low while the FIFO holds `FIFO_DEPTH` words. No more than the total length is ever requested.
- R6: Acknowledge 0x1 completes a packet with no response. Acknowledge 0x2 makes the sequencer wait for a response with transaction code 0x2 and the packet's label. Responses with another code or label are ignored. Response code 0x0 means success.
- R7: After each successful packet, the address grows by 4 times the payload words and the remaining length drops by the payload words. The last packet carries only the words that remain. The transfer ends with `done` high, `error` low and `remWords` zero.
- R8: An acknowledge other than 0x1 or 0x2, or a matched response code other than 0x0, ends the transfer. The sequencer then sets `done` and `error`, and pulses `irq` high for exactly one cycle. `statAck` holds the last acknowledge and `statRsp` the last response code, which is 0 when no response was taken.
- R9: A matching response is accepted if it arrives 1 to `cfgTimeout`+1 cycles after the cycle that carried the pending acknowledge. If none arrives by then, the sequencer takes the error exit with `statRsp` = 0xF.
- R10: `done` and `error` clear in the cycle after an accepted `start`. A transfer of length 0 sets `done` without sending any packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| cfgAddr | input | 32 | Destination byte address |
| cfgLen | input | LEN_W | Total length in words |
| cfgPkt | input | LEN_W | Payload words per packet (1..FIFO_DEPTH) |
| cfgTimeout | input | TO_W | Response wait limit in cycles |
| dataReq | output | 1 | Request to the decoder |
| dataVld | input | 1 | Decoder word valid |
| dataIn | input | 32 | Decoder word |
| linkVld | output | 1 | Packet word valid toward the link core |
| linkSop | output | 1 | First header word |
| linkEop | output | 1 | Last payload word |
| linkData | output | 32 | Packet word |
| linkRdy | input | 1 | Link core accepts the word |
| ackVld | input | 1 | Acknowledge code valid |
| ackCode | input | 4 | Acknowledge code |
| rspVld | input | 1 | Received response valid |
| rspTcode | input | 4 | Response transaction code |
| rspLabel | input | 6 | Response transaction label |
| rspCode | input | 4 | Response result code |
| busy | output | 1 | Transfer running |
| done | output | 1 | Transfer ended |
| error | output | 1 | Transfer ended in error |
| irq | output | 1 | One-cycle interrupt on error |
| statAck | output | 4 | Last acknowledge code |
| statRsp | output | 4 | Last response code, 0xF on timeout |
| curAddr | output | 32 | Current destination byte address |
| remWords | output | LEN_W | Words still to be sent |

## Verification
Two functions can fall on the same clock edge. One is the decoder writing a word into the transmit FIFO. The other is the link side reading a payload word out of it. A count or pointer slip then shows up as lost, repeated or reordered payload.

The bench provokes this overlap in two ways. It keeps `dataVld` and `linkRdy` high with packets smaller than the FIFO. It also runs alternating-valid and ready-gap patterns, so that writes and reads mix with every phase offset. A scoreboard compares each accepted link word, with its start and end flags, against the header and a sequential payload predicted from the settings. At the end of each run it also checks the total number of words taken from the decoder.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
  localparam int DATA_W = 32;
  localparam logic [3:0] TCODE_BWR     = 4'h1;
  localparam logic [3:0] TCODE_WRSP    = 4'h2;
  localparam logic [3:0] ACK_DONE      = 4'h1;
  localparam logic [3:0] ACK_PEND      = 4'h2;
  localparam logic [3:0] RCODE_OK      = 4'h0;
  localparam logic [3:0] RCODE_TIMEOUT = 4'hF;

  typedef enum logic [1:0] {SEL_NONE, SEL_HDR0, SEL_HDR1, SEL_PAY} outSel_e;

  typedef struct packed {
    logic    load;
    logic    advance;
    outSel_e sel;
  } ctlStrobe_t;
endpackage

// File: rtl/blkwr_dpath.sv
module blkwr_dpath
  import blkwr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              active,
  input  logic [5:0]        label,
  input  logic [31:0]       cfgAddr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [LEN_W-1:0]  cfgPkt,
  input  logic              dataVld,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataReq,
  input  logic              linkRdy,
  output logic [DATA_W-1:0] linkData,
  output logic              pktReady,
  output logic [LEN_W-1:0]  curPkt,
  output logic [LEN_W-1:0]  remWords,
  output logic [31:0]       curAddr
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       addrQ;
  logic [LEN_W-1:0]  remQ, reqLeft, pktQ;
  logic              push, pop;
  logic [15:0]       pktBytes;

  assign curPkt   = (remQ < pktQ) ? remQ : pktQ;
  assign pktBytes = 16'({curPkt, 2'b00});
  assign dataReq  = active && (reqLeft != '0) && (cnt != CNT_W'(FIFO_DEPTH));
  assign push     = dataReq && dataVld;
  assign pop      = (strobe.sel == SEL_PAY) && linkRdy;
  assign pktReady = (LEN_W'(cnt) >= curPkt);
  assign remWords = remQ;
  assign curAddr  = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      addrQ   <= '0;
      remQ    <= '0;
      reqLeft <= '0;
      pktQ    <= '0;
    end else if (strobe.load) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      addrQ   <= cfgAddr;
      remQ    <= cfgLen;
      reqLeft <= cfgLen;
      pktQ    <= cfgPkt;
    end else begin
      if (push) begin
        wrPtr   <= wrPtr + PTR_W'(1);
        reqLeft <= reqLeft - LEN_W'(1);
      end
      if (pop) rdPtr <= rdPtr + PTR_W'(1);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      if (strobe.advance) begin
        addrQ <= addrQ + 32'({curPkt, 2'b00});
        remQ  <= remQ - curPkt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= dataIn;
  end

  always_comb begin
    case (strobe.sel)
      SEL_HDR0: linkData = {pktBytes, label, 2'b00, TCODE_BWR, 4'h0};
      SEL_HDR1: linkData = addrQ;
      SEL_PAY:  linkData = mem[rdPtr];
      default:  linkData = '0;
    endcase
  end
endmodule

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TO_W-1:0]  cfgTimeout,
  input  logic             pktReady,
  input  logic [LEN_W-1:0] curPkt,
  input  logic [LEN_W-1:0] remWords,
  input  logic             linkRdy,
  input  logic             ackVld,
  input  logic [3:0]       ackCode,
  input  logic             rspVld,
  input  logic [3:0]       rspTcode,
  input  logic [5:0]       rspLabel,
  input  logic [3:0]       rspCode,
  output ctlStrobe_t       strobe,
  output logic [5:0]       label,
  output logic             linkVld,
  output logic             linkSop,
  output logic             linkEop,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             irq,
  output logic [3:0]       statAck,
  output logic [3:0]       statRsp
);
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_HDR0, S_HDR1, S_PAY, S_ACK, S_RSP} state_e;

  state_e           state;
  logic [LEN_W-1:0] payCnt;
  logic [TO_W-1:0]  toCnt;
  logic             ackIn, rspMatch, goodAck, goodRsp, fail;

  assign ackIn    = (state == S_ACK) && ackVld;
  assign rspMatch = (state == S_RSP) && rspVld && (rspTcode == TCODE_WRSP) && (rspLabel == label);
  assign goodAck  = ackIn && (ackCode == ACK_DONE);
  assign goodRsp  = rspMatch && (rspCode == RCODE_OK);
  assign fail     = (ackIn && (ackCode != ACK_DONE) && (ackCode != ACK_PEND))
                 || (rspMatch && (rspCode != RCODE_OK))
                 || ((state == S_RSP) && !rspMatch && (toCnt == cfgTimeout));

  assign busy    = (state != S_IDLE);
  assign linkVld = (state == S_HDR0) || (state == S_HDR1) || (state == S_PAY);
  assign linkSop = (state == S_HDR0);
  assign linkEop = (state == S_PAY) && (payCnt == curPkt - LEN_W'(1));

  always_comb begin
    strobe.load    = (state == S_IDLE) && start;
    strobe.advance = goodAck || goodRsp;
    case (state)
      S_HDR0:  strobe.sel = SEL_HDR0;
      S_HDR1:  strobe.sel = SEL_HDR1;
      S_PAY:   strobe.sel = SEL_PAY;
      default: strobe.sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      label   <= '0;
      payCnt  <= '0;
      toCnt   <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      irq     <= 1'b0;
      statAck <= '0;
      statRsp <= '0;
    end else begin
      irq <= fail;
      if (fail) begin
        state <= S_IDLE;
        done  <= 1'b1;
        error <= 1'b1;
        label <= label + 6'd1;
      end
      case (state)
        S_IDLE: if (start) begin
          done  <= 1'b0;
          error <= 1'b0;
          state <= S_FILL;
        end
        S_FILL: begin
          if (remWords == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (pktReady) begin
            state <= S_HDR0;
          end
        end
        S_HDR0: if (linkRdy) state <= S_HDR1;
        S_HDR1: if (linkRdy) begin
          state  <= S_PAY;
          payCnt <= '0;
        end
        S_PAY: if (linkRdy) begin
          if (linkEop) state <= S_ACK;
          else payCnt <= payCnt + LEN_W'(1);
        end
        S_ACK: if (ackVld) begin
          statAck <= ackCode;
          statRsp <= RCODE_OK;
          toCnt   <= '0;
          if (goodAck) begin
            state <= S_FILL;
            label <= label + 6'd1;
          end else if (ackCode == ACK_PEND) begin
            state <= S_RSP;
          end
        end
        S_RSP: begin
          if (rspMatch) begin
            statRsp <= rspCode;
            if (goodRsp) begin
              state <= S_FILL;
              label <= label + 6'd1;
            end
          end else if (toCnt == cfgTimeout) begin
            statRsp <= RCODE_TIMEOUT;
          end else begin
            toCnt <= toCnt + TO_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkwr_tx_seq.sv
module blkwr_tx_seq
  import blkwr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 16,
  parameter int TO_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       cfgAddr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [LEN_W-1:0]  cfgPkt,
  input  logic [TO_W-1:0]   cfgTimeout,
  output logic              dataReq,
  input  logic              dataVld,
  input  logic [DATA_W-1:0] dataIn,
  output logic              linkVld,
  output logic              linkSop,
  output logic              linkEop,
  output logic [DATA_W-1:0] linkData,
  input  logic              linkRdy,
  input  logic              ackVld,
  input  logic [3:0]        ackCode,
  input  logic              rspVld,
  input  logic [3:0]        rspTcode,
  input  logic [5:0]        rspLabel,
  input  logic [3:0]        rspCode,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              irq,
  output logic [3:0]        statAck,
  output logic [3:0]        statRsp,
  output logic [31:0]       curAddr,
  output logic [LEN_W-1:0]  remWords
);
  ctlStrobe_t       strobe;
  logic [5:0]       label;
  logic             pktReady;
  logic [LEN_W-1:0] curPkt;

  blkwr_ctrl #(.LEN_W(LEN_W), .TO_W(TO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgTimeout(cfgTimeout),
    .pktReady(pktReady), .curPkt(curPkt), .remWords(remWords), .linkRdy(linkRdy),
    .ackVld(ackVld), .ackCode(ackCode), .rspVld(rspVld), .rspTcode(rspTcode),
    .rspLabel(rspLabel), .rspCode(rspCode), .strobe(strobe), .label(label),
    .linkVld(linkVld), .linkSop(linkSop), .linkEop(linkEop), .busy(busy),
    .done(done), .error(error), .irq(irq), .statAck(statAck), .statRsp(statRsp)
  );

  blkwr_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(busy), .label(label),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgPkt(cfgPkt), .dataVld(dataVld),
    .dataIn(dataIn), .dataReq(dataReq), .linkRdy(linkRdy), .linkData(linkData),
    .pktReady(pktReady), .curPkt(curPkt), .remWords(remWords), .curAddr(curAddr)
  );
endmodule

// File: rtl/blkwr_chk.sv
module blkwr_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             dataReq,
  input logic             linkVld,
  input logic             linkSop,
  input logic             linkEop,
  input logic [31:0]      linkData,
  input logic             linkRdy,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             irq,
  input logic [31:0]      curAddr,
  input logic [LEN_W-1:0] remWords
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!linkVld && !dataReq));

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done && !error && linkVld && !linkRdy) |=> busy);

  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> busy);

  assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkVld && !linkRdy) |=> (linkVld && $stable(linkData) && $stable(linkSop) && $stable(linkEop)));

  assert_gap_after_eop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkVld && linkRdy && linkEop) |=> !linkVld);

  assert_irq_with_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (error && done && !busy));

  assert_error_raises_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> irq);

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done && !error));

  assert_idle_state_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(curAddr) && $stable(remWords)));
endmodule

bind blkwr_tx_seq blkwr_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .dataReq(dataReq), .linkVld(linkVld),
  .linkSop(linkSop), .linkEop(linkEop), .linkData(linkData), .linkRdy(linkRdy),
  .busy(busy), .done(done), .error(error), .irq(irq), .curAddr(curAddr),
  .remWords(remWords)
);

// File: tb/blkwr_tx_seq_tb_top.sv
module blkwr_tx_seq_tb_top;
  import blkwr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FIFO_DEPTH = 16;
  localparam int LEN_W      = 16;
  localparam int TO_W       = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] cfgAddr = '0;
  logic [LEN_W-1:0] cfgLen = '0, cfgPkt = '0;
  logic [TO_W-1:0] cfgTimeout = '0;
  logic dataReq, dataVld = 1'b0;
  logic [31:0] dataIn = '0;
  logic linkVld, linkSop, linkEop, linkRdy = 1'b0;
  logic [31:0] linkData;
  logic ackVld = 1'b0, rspVld = 1'b0;
  logic [3:0] ackCode = '0, rspTcode = '0, rspCode = '0;
  logic [5:0] rspLabel = '0;
  logic busy, done, error, irq;
  logic [3:0] statAck, statRsp;
  logic [31:0] curAddr;
  logic [LEN_W-1:0] remWords;

  blkwr_tx_seq #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .TO_W(TO_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgAddr(cfgAddr), .cfgLen(cfgLen),
    .cfgPkt(cfgPkt), .cfgTimeout(cfgTimeout), .dataReq(dataReq), .dataVld(dataVld),
    .dataIn(dataIn), .linkVld(linkVld), .linkSop(linkSop), .linkEop(linkEop),
    .linkData(linkData), .linkRdy(linkRdy), .ackVld(ackVld), .ackCode(ackCode),
    .rspVld(rspVld), .rspTcode(rspTcode), .rspLabel(rspLabel), .rspCode(rspCode),
    .busy(busy), .done(done), .error(error), .irq(irq), .statAck(statAck),
    .statRsp(statRsp), .curAddr(curAddr), .remWords(remWords)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] ack;
    int         dly;
    logic [3:0] rcode;
    bit         junk;
    logic [5:0] lbl;
  } plan_t;

  plan_t       planQ[$];
  logic [33:0] expQ[$];
  int checks = 0, errors = 0;
  int srcVal = 1, accCnt = 0, irqCnt = 0, cyc = 0;
  int vldMode = 0, rdyMode = 0;
  bit accepted = 0;
  logic [5:0] lblNext = '0;
  logic [31:0] expAddr;
  int expRem;
  bit expErr;
  logic [3:0] expAck, expRsp;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // decoder source and link ready pattern, driven after the edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    if (accepted) srcVal++;
    dataIn  = 32'(srcVal);
    dataVld = (vldMode == 0) ? 1'b1 : cyc[0];
    linkRdy = (rdyMode == 0) ? 1'b1 : (rdyMode == 1) ? ((cyc % 3) != 0) : 1'b0;
  end

  // monitor: decoder acceptance, scoreboard pop, irq count
  initial forever begin
    @(negedge clk);
    accepted = dataReq && dataVld;
    if (accepted) accCnt++;
    if (irq) irqCnt++;
    if (linkVld && linkRdy) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected link word: actual=%0h expected=none", linkData);
      end else begin
        chk("R3/R4", "link word", {30'd0, linkSop, linkEop, linkData}, {30'd0, expQ.pop_front()});
      end
    end
  end

  // responder: ack and optional write response after each packet
  initial forever begin
    @(negedge clk);
    if (linkVld && linkRdy && linkEop) begin
      plan_t p;
      if (planQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 packet without plan: actual=1 expected=0");
      end else begin
        p = planQ.pop_front();
        repeat (2) @(posedge clk);
        #1 ackVld = 1'b1; ackCode = p.ack;
        @(posedge clk); #1 ackVld = 1'b0;
        if (p.ack == ACK_PEND) begin
          for (int d = 1; d <= p.dly; d++) begin
            rspVld = 1'b1; rspTcode = TCODE_WRSP; rspLabel = p.lbl; rspCode = p.rcode;
            if (d != p.dly) begin
              if (p.junk && d == 1) begin rspLabel = p.lbl + 6'd1; rspCode = 4'h0; end      // R6 wrong label
              else if (p.junk && d == 2) begin rspTcode = 4'h6; rspCode = 4'h0; end         // R6 wrong code
              else rspVld = 1'b0;
            end
            @(posedge clk); #1;
          end
          rspVld = 1'b0;
        end
      end
    end
  end

  task automatic add_plan(input logic [3:0] ack, input int dly, input logic [3:0] rc, input bit junk);
    plan_t p;
    p.ack = ack; p.dly = dly; p.rcode = rc; p.junk = junk; p.lbl = '0;
    planQ.push_back(p);
  endtask

  task automatic start_xfer(input logic [31:0] addr, input int len, input int pkt, input int to, input bit poke);
    int base, off, rem, idx, n;
    bit ok;
    base = srcVal; off = 0; rem = len; idx = 0;
    expAddr = addr; expErr = 0; expAck = 4'h0; expRsp = 4'h0;
    while (rem > 0 && !expErr) begin
      n = (pkt < rem) ? pkt : rem;
      planQ[idx].lbl = lblNext;
      expQ.push_back({1'b1, 1'b0, 16'(n * 4), lblNext, 2'b00, TCODE_BWR, 4'h0});
      expQ.push_back({1'b0, 1'b0, expAddr});
      for (int i = 0; i < n; i++) expQ.push_back({1'b0, (i == n - 1), 32'(base + off + i)});
      lblNext = lblNext + 6'd1;
      expAck = planQ[idx].ack;
      if (planQ[idx].ack == ACK_DONE) begin
        expRsp = 4'h0; ok = 1;
      end else if (planQ[idx].ack == ACK_PEND) begin
        if (planQ[idx].dly >= 1 && planQ[idx].dly <= to + 1) begin
          expRsp = planQ[idx].rcode; ok = (planQ[idx].rcode == 4'h0);
        end else begin
          expRsp = 4'hF; ok = 0;
        end
      end else begin
        expRsp = 4'h0; ok = 0;
      end
      if (ok) begin
        expAddr = expAddr + 32'(4 * n); rem = rem - n; off = off + n;
      end else expErr = 1;
      idx++;
    end
    expRem = rem;
    cfgAddr = addr; cfgLen = LEN_W'(len); cfgPkt = LEN_W'(pkt); cfgTimeout = TO_W'(to);
    accCnt = 0; irqCnt = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk("R10", "done cleared on start", {62'd0, busy, done}, {62'd0, 1'b1, 1'b0});
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 cfgAddr = 32'hDEAD0000; cfgLen = LEN_W'(3); start = 1'b1;   // R1 ignored while busy
      @(posedge clk); #1 start = 1'b0;
    end
  endtask

  task automatic finish_xfer(input int len);
    int waitCnt = 0;
    while (!done && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    repeat (2) @(negedge clk);
    chk("R7", "done", {63'd0, done}, 64'd1);
    chk("R8", "error", {63'd0, error}, {63'd0, expErr});
    if (len > 0) begin
      chk("R8", "statAck", {60'd0, statAck}, {60'd0, expAck});
      chk("R9", "statRsp", {60'd0, statRsp}, {60'd0, expRsp});
    end
    chk("R7", "curAddr", {32'd0, curAddr}, {32'd0, expAddr});
    chk("R7", "remWords", {48'd0, remWords}, 64'(expRem));
    chk("R8", "irq pulses", 64'(irqCnt), 64'(expErr));
    chk("R4", "words left in scoreboard", 64'(expQ.size()), 64'd0);
    chk("R6", "plans left", 64'(planQ.size()), 64'd0);
    if (!expErr) chk("R5", "words requested", 64'(accCnt), 64'(len));
    expQ.delete(); planQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {58'd0, busy, done, error, irq, dataReq, linkVld}, 64'd0);

    // R7 basic: 10 words in packets of 4, complete acks, remainder 2
    vldMode = 0; rdyMode = 0;
    repeat (3) add_plan(ACK_DONE, 0, 4'h0, 0);
    start_xfer(32'h0000_1000, 10, 4, 5, 0);
    finish_xfer(10);

    // R6 pending acks with ignored mismatching responses, backpressure, R1 restart ignored
    vldMode = 1; rdyMode = 1;
    repeat (3) add_plan(ACK_PEND, 4, 4'h0, 1);
    start_xfer(32'h2000_0000, 12, 5, 6, 1);
    finish_xfer(12);

    // R8 bad ack code on second packet
    vldMode = 0; rdyMode = 0;
    add_plan(ACK_DONE, 0, 4'h0, 0);
    add_plan(4'h4, 0, 4'h0, 0);
    start_xfer(32'h0000_0300, 20, 4, 5, 0);
    finish_xfer(20);

    // R8 bad response code
    add_plan(ACK_PEND, 2, 4'h6, 0);
    start_xfer(32'h0000_0400, 8, 8, 5, 0);
    finish_xfer(8);

    // R9 no response: timeout
    add_plan(ACK_PEND, 0, 4'h0, 0);
    start_xfer(32'h0000_0800, 4, 4, 5, 0);
    finish_xfer(4);

    // R9 response in the last allowed cycle, single short packet
    add_plan(ACK_PEND, 6, 4'h0, 0);
    start_xfer(32'h0000_0900, 3, 8, 5, 0);
    finish_xfer(3);

    // R10 zero length
    start_xfer(32'h0000_0500, 0, 4, 5, 0);
    finish_xfer(0);

    // R5 full FIFO stops the request
    rdyMode = 2;
    repeat (3) add_plan(ACK_DONE, 0, 4'h0, 0);
    start_xfer(32'h0000_0600, 40, 16, 5, 0);
    repeat (40) @(negedge clk);
    chk("R5", "request low when full", {63'd0, dataReq}, 64'd0);
    chk("R5", "words held at full", 64'(accCnt), 64'(FIFO_DEPTH));
    rdyMode = 0;
    finish_xfer(40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule